// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generate and Check

This block connects two 8-bit data ports, called A and B, and passes data between them in the direction that a direction input selects. With the direction input high the block transmits: A-side data goes out on the B side. With it low the block receives: B-side data goes out on the A side. Data bits pass through without inversion. An active-low enable input turns off every driver at once.

Parity handling follows the transfer direction. In transmit the block generates a parity bit from the A data and an odd/even select, and drives that bit on the parity pin. In receive the parity pin becomes an input. The block checks the B data, the select and the incoming parity bit, and drives an active-low error flag. The flag is high when the parity is correct.

Every tri-stateable pin is split into a data input, a data output and an active-high drive enable, so the block fits inside a chip with no internal tri-state nets. The block is purely combinational, with no clock and no state. Its outputs follow its inputs in the same evaluation.

Top module: `xcvr_parity`

## Requirements
- R1: With `en_n` low and `dir_tx` high, `b_out` equals `a_in`, every bit of `b_oe` is 1 and every bit of `a_oe` is 0.
- R2: With `en_n` low and `dir_tx` low, `a_out` equals `b_in`, every bit of `a_oe` is 1 and every bit of `b_oe` is 0.
- R3: With `en_n` high, `a_oe`, `b_oe`, `par_oe` and `err_oe` are all 0, whatever the other inputs are.
- R4: In transmit with `en_n` low, `par_oe` is 1 and `par_out` equals `odd_sel` XOR the XOR of all eight `a_in` bits. For example, an even count of ones with `odd_sel` high gives `par_out` = 1.
- R5: In receive with `en_n` low, `err_oe` is 1 and `err_n_out` equals NOT(`par_in` XOR `odd_sel` XOR the XOR of all eight `b_in` bits). For example, an even count of ones on B with `odd_sel` = 1 and `par_in` = 1 gives 1 (no error), and an odd count under the same inputs gives 0 (error).
- R6: `err_oe` is 0 in transmit, and `par_oe` is 0 in receive, so the parity pin is not driven while it serves as an input.
- R7: No bit position has `a_oe` and `b_oe` set together.
- R8: The data path does not invert. Each output bit equals the input bit at the same position on the opposite port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Active-low enable. When high, all drive enables are 0 |
| dir_tx | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| odd_sel | input | 1 | Odd/even parity select |
| a_in | input | 8 | Data sensed on the A pins |
| b_in | input | 8 | Data sensed on the B pins |
| par_in | input | 1 | Parity bit sensed on the parity pin |
| a_out | output | 8 | Data to drive on the A pins |
| a_oe | output | 8 | Per-bit drive enable for the A pins |
| b_out | output | 8 | Data to drive on the B pins |
| b_oe | output | 8 | Per-bit drive enable for the B pins |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_n_out | output | 1 | Active-low parity error flag |
| err_oe | output | 1 | Drive enable for the error pin |

## Verification
The bench applies every 8-bit value to A, and at the same time a scrambled value to B, under every combination of direction, enable, select and incoming parity bit. Because the data sweeps every count of ones, a generate or check term that drops a bit, or that uses the wrong polarity for the select, is exposed. Because the A and B values differ in each vector, a path that takes its data from the wrong port is exposed. Holding the enable high across the full sweep shows that no drive enable leaks through in any mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        XFER_RX = 1'b0,
        XFER_TX = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic a_side;
        logic b_side;
        logic par_drv;
        logic err_drv;
    } drive_sel_t;

endpackage

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic       en_n,
    input  xfer_dir_e  dir,
    output drive_sel_t sel
);
    drive_sel_t sel_d;

    always_comb begin
        sel_d = '0;
        if (!en_n) begin
            sel_d.b_side  = (dir == XFER_TX);
            sel_d.par_drv = (dir == XFER_TX);
            sel_d.a_side  = (dir == XFER_RX);
            sel_d.err_drv = (dir == XFER_RX);
        end
    end

    assign sel = sel_d;

    always_comb begin
        assert_one_side_R7: assert (!(sel_d.a_side && sel_d.b_side))
            else $error("both data sides selected");
    end
endmodule

// File: rtl/xcvr_parity_tree.sv
module xcvr_parity_tree #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic              odd
);
    logic [DATA_W:0] acc;

    assign acc[0] = 1'b0;
    for (genvar i = 0; i < DATA_W; i++) begin : g_stage
        assign acc[i+1] = acc[i] ^ data[i];
    end

    assign odd = acc[DATA_W];
endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              en_n,
    input  logic              dir_tx,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              par_in,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] a_oe,
    output logic [DATA_W-1:0] b_out,
    output logic [DATA_W-1:0] b_oe,
    output logic              par_out,
    output logic              par_oe,
    output logic              err_n_out,
    output logic              err_oe
);
    typedef struct packed {
        logic [DATA_W-1:0] a_dat;
        logic [DATA_W-1:0] a_en;
        logic [DATA_W-1:0] b_dat;
        logic [DATA_W-1:0] b_en;
        logic              par;
        logic              par_en;
        logic              err_n;
        logic              err_en;
    } pins_t;

    drive_sel_t sel;
    logic       a_odd;
    logic       b_odd;
    pins_t      pins_d;

    xcvr_drive_ctl u_ctl (
        .en_n (en_n),
        .dir  (xfer_dir_e'(dir_tx)),
        .sel  (sel)
    );

    xcvr_parity_tree #(.DATA_W(DATA_W)) u_tree_a (
        .data (a_in),
        .odd  (a_odd)
    );

    xcvr_parity_tree #(.DATA_W(DATA_W)) u_tree_b (
        .data (b_in),
        .odd  (b_odd)
    );

    always_comb begin
        pins_d.a_dat  = b_in;
        pins_d.b_dat  = a_in;
        pins_d.par    = odd_sel ^ a_odd;
        pins_d.err_n  = ~(par_in ^ odd_sel ^ b_odd);
        pins_d.par_en = sel.par_drv;
        pins_d.err_en = sel.err_drv;
        for (int i = 0; i < DATA_W; i++) begin
            pins_d.a_en[i] = sel.a_side;
            pins_d.b_en[i] = sel.b_side;
        end
    end

    assign a_out     = pins_d.a_dat;
    assign a_oe      = pins_d.a_en;
    assign b_out     = pins_d.b_dat;
    assign b_oe      = pins_d.b_en;
    assign par_out   = pins_d.par;
    assign par_oe    = pins_d.par_en;
    assign err_n_out = pins_d.err_n;
    assign err_oe    = pins_d.err_en;

    always_comb begin
        assert_no_overlap_R7: assert ((a_oe & b_oe) == '0)
            else $error("A and B drive enables overlap");
        assert_off_when_disabled_R3: assert (!en_n || (a_oe == '0 && b_oe == '0 && !par_oe && !err_oe))
            else $error("driver on while disabled");
        assert_pin_roles_R6: assert (!(par_oe && err_oe))
            else $error("parity and error pins driven together");
        assert_gen_value_R4: assert (!par_oe || (par_out == (odd_sel ^ (^a_in))))
            else $error("generated parity wrong");
        assert_chk_value_R5: assert (!err_oe || (err_n_out == !(par_in ^ odd_sel ^ (^b_in))))
            else $error("check flag wrong");
    end
endmodule

// File: tb/sim_xcvr_parity.sv
module sim_xcvr_parity;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] a_out, a_oe, b_out, b_oe;
        logic         par_out, par_oe, err_n, err_oe;
        logic         en_n, dir;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         en_n = 1'b1, dir_tx = 1'b0, odd_sel = 1'b0, par_in = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         par_out, par_oe, err_n_out, err_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    xcvr_parity #(.DATA_W(W)) u0 (
        .en_n(en_n), .dir_tx(dir_tx), .odd_sel(odd_sel),
        .a_in(a_in), .b_in(b_in), .par_in(par_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .par_out(par_out), .par_oe(par_oe),
        .err_n_out(err_n_out), .err_oe(err_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic d, input logic s,
                         input logic p, input logic [W-1:0] av, input logic [W-1:0] bv);
        exp_t x;
        @(posedge clk);
        en_n = e; dir_tx = d; odd_sel = s; par_in = p; a_in = av; b_in = bv;
        x.en_n    = e;
        x.dir     = d;
        x.a_out   = bv;
        x.b_out   = av;
        x.a_oe    = (!e && !d) ? '1 : '0;
        x.b_oe    = (!e && d) ? '1 : '0;
        x.par_out = s ^ (^av);
        x.par_oe  = !e && d;
        x.err_n   = !(p ^ s ^ (^bv));
        x.err_oe  = !e && !d;
        q.push_back(x);
    endtask

    // monitor: pops expected items at the falling edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            if (x.en_n) begin
                chk("R3 a_oe", a_oe, x.a_oe);
                chk("R3 b_oe", b_oe, x.b_oe);
                chk("R3 par_oe", {7'd0, par_oe}, {7'd0, x.par_oe});
                chk("R3 err_oe", {7'd0, err_oe}, {7'd0, x.err_oe});
            end else if (x.dir) begin
                chk("R1 b_out", b_out, x.b_out);
                chk("R1 b_oe", b_oe, x.b_oe);
                chk("R1 a_oe", a_oe, x.a_oe);
                chk("R4 par_out", {7'd0, par_out}, {7'd0, x.par_out});
                chk("R4 par_oe", {7'd0, par_oe}, {7'd0, x.par_oe});
                chk("R6 err_oe", {7'd0, err_oe}, {7'd0, x.err_oe});
            end else begin
                chk("R2 a_out", a_out, x.a_out);
                chk("R2 a_oe", a_oe, x.a_oe);
                chk("R2 b_oe", b_oe, x.b_oe);
                chk("R5 err_n", {7'd0, err_n_out}, {7'd0, x.err_n});
                chk("R5 err_oe", {7'd0, err_oe}, {7'd0, x.err_oe});
                chk("R6 par_oe", {7'd0, par_oe}, {7'd0, x.par_oe});
            end
            chk("R7 overlap", a_oe & b_oe, '0);
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // disabled state before any traffic (R3)
        @(negedge clk);
        chk("R3 idle a_oe", a_oe, '0);
        chk("R3 idle b_oe", b_oe, '0);
        // R8: walking one in both directions, no inversion
        for (int i = 0; i < W; i++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b0, W'(1) << i, '0);
            @(negedge clk);
            chk("R8 tx bit", b_out, W'(1) << i);
            drive(1'b0, 1'b0, 1'b0, 1'b0, '0, ~(W'(1) << i));
            @(negedge clk);
            chk("R8 rx bit", a_out, ~(W'(1) << i));
        end
        // R5 worked cases: even count -> no error, odd count -> error
        drive(1'b0, 1'b0, 1'b1, 1'b1, '0, 8'h33);
        @(negedge clk);
        chk("R5 even ok", {7'd0, err_n_out}, 8'd1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, '0, 8'h31);
        @(negedge clk);
        chk("R5 odd err", {7'd0, err_n_out}, 8'd0);
        // R4 worked case: even count, select high -> parity 1
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h0F, '0);
        @(negedge clk);
        chk("R4 even sel1", {7'd0, par_out}, 8'd1);
        // full sweep
        for (int e = 0; e < 2; e++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 2; s++)
                    for (int p = 0; p < 2; p++)
                        for (int v = 0; v < 256; v++)
                            drive(e[0], d[0], s[0], p[0], v[7:0], (v[7:0] * 8'd37) ^ 8'hA5);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule